// File: doc/BRIEF.md
# Destination Register Renamer with Pinned Writes

This block assigns a physical register to each destination named by a renamed micro-op. Register renaming normally gives every write a fresh physical register taken from a free pool. That is a poor fit for a micro-coded sequence whose micro-ops each fill a different slice of one destination: each fresh register would need the slices written so far, which builds a read-modify-write chain. A requester can instead ask for a pin count N. The first rename then allocates as usual and records N. The next N renames of that architectural register return the same physical register, each one decrementing the count, and take nothing from the pool.

Each accepted rename reports the new and previous physical index, the pin state of the result, and a one-cycle pulse that clears the result's ready bit in a scoreboard. Every accepted rename also records (architectural index, new, previous) in a history buffer. A squash removes the youngest record each cycle and puts the previous mapping back. Retirement drops the oldest record. Released physical registers come back through a return port.

Top module: `pin_rename`

## Requirements
- R1: After reset, architectural register i maps to physical register i. The free pool holds physical registers ARCH_REGS to PHYS_REGS-1, and fresh allocations hand them out in ascending order.
- R2: A rename of architectural register 0 returns physical 0 as both new and previous index. It consumes no pool entry and changes no counter.
- R3: When the current mapping has a pin count of zero, a rename takes the pool head, writes it into the map, reports the old mapping as previous, and reports a remaining pin count equal to the requested count.
- R4: A fresh allocation sets the register's completion count (ren_wtc) to the requested pin count plus one. A pinned reuse reports that stored completion count unchanged.
- R5: When the current mapping's pin count is above zero, the rename returns that same register as both new and previous index. It takes nothing from the pool and reports the pin count reduced by one.
- R6: ren_pinned is 1 exactly when the allocating request had a nonzero pin count. It stays 1 on every reuse, including the one that drains the count to zero.
- R7: A request with a nonzero pin count whose current mapping still has a nonzero pin count raises pin_error in that cycle. The request is then handled as a plain reuse (R5).
- R8: Every accepted rename (ren_valid high and ren_stall low) pulses sb_clr_valid in that cycle, with sb_clr_idx equal to ren_phys.
- R9: If a fresh allocation is needed while the pool is empty, ren_stall is 1, sb_clr_valid is 0, and the map and pool are left unchanged. A zero-register rename is still accepted while the pool is empty.
- R10: Registers presented on free_valid/free_idx join the back of the pool in the order they arrive.
- R11: Each squash cycle removes the youngest history record. It restores that record's previous index into the map only when the new and previous indices differ. A squash with an empty history does nothing.
- R12: ren_stall is 1 while squash_valid is high, and also when the history already holds HIST_DEPTH records.
- R13: retire_valid (without squash) removes the oldest history record, so a later squash can no longer undo that rename.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Rename request |
| ren_arch | input | $clog2(ARCH_REGS) | Architectural destination index |
| ren_pin | input | PIN_W | Requested number of further pinned writes |
| ren_stall | output | 1 | Request not accepted this cycle |
| ren_phys | output | $clog2(PHYS_REGS) | Physical register assigned |
| ren_prev | output | $clog2(PHYS_REGS) | Mapping before this rename |
| ren_left | output | PIN_W | Pin count of the result after this rename |
| ren_wtc | output | PIN_W+1 | Completion count of the result |
| ren_pinned | output | 1 | Result was allocated with a nonzero pin count |
| pin_error | output | 1 | Pin requested on a still-pinned mapping |
| sb_clr_valid | output | 1 | Scoreboard ready-clear pulse |
| sb_clr_idx | output | $clog2(PHYS_REGS) | Register whose ready bit is cleared |
| free_valid | input | 1 | Return a register to the pool |
| free_idx | input | $clog2(PHYS_REGS) | Returned register |
| squash_valid | input | 1 | Undo the youngest rename |
| retire_valid | input | 1 | Drop the oldest history record |

## Verification
The bound checker watches the following on every cycle:
- A zero-register rename always yields physical 0.
- A pinned reuse returns its previous register, keeps the pinned flag set, and never pops the pool.
- pin_error only appears on a reuse.
- The pool is never popped while empty.
- A squash blocks renaming and shrinks the history by exactly one.

Other behaviours can only be shown by the bench scenarios:
- the ascending allocation order after reset;
- the completion count loaded as pin plus one;
- the order in which returned registers come back out of the pool;
- the restored mapping after a squash, seen through the previous index of a later rename;
- the fact that a retired rename survives a squash.

// File: rtl/pin_rename_pkg.sv
package pin_rename_pkg;

  typedef enum logic [1:0] {
    RK_ZERO  = 2'd0,
    RK_REUSE = 2'd1,
    RK_FRESH = 2'd2
  } ren_kind_e;

  // completion count loaded at a fresh allocation
  function automatic int fresh_wtc(int pin);
    return pin + 1;
  endfunction

  // pin count after one pinned reuse
  function automatic int drain_one(int cnt);
    return cnt - 1;
  endfunction

  function automatic int ring_inc(int p, int n);
    return (p == n - 1) ? 0 : p + 1;
  endfunction

  function automatic int ring_dec(int p, int n);
    return (p == 0) ? n - 1 : p - 1;
  endfunction

endpackage

// File: rtl/rn_freelist.sv
module rn_freelist
  import pin_rename_pkg::*;
#(
  parameter int ARCH_REGS = 8,
  parameter int PHYS_REGS = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         pop,
  input  logic                         push,
  input  logic [$clog2(PHYS_REGS)-1:0] push_idx,
  output logic [$clog2(PHYS_REGS)-1:0] head_idx,
  output logic                         empty,
  output logic [$clog2(PHYS_REGS+1)-1:0] count
);
  localparam int IW    = $clog2(PHYS_REGS);
  localparam int CW    = $clog2(PHYS_REGS + 1);
  localparam int NFREE = PHYS_REGS - ARCH_REGS;

  logic [IW-1:0] slot [PHYS_REGS];
  logic [IW-1:0] head, tail;
  logic          push_ok, pop_ok;

  assign empty    = (count == '0);
  assign push_ok  = push && (count != CW'(PHYS_REGS));
  assign pop_ok   = pop && !empty;
  assign head_idx = slot[head];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PHYS_REGS; i++)
        slot[i] <= (i < NFREE) ? IW'(ARCH_REGS + i) : '0;
      head  <= '0;
      tail  <= IW'(NFREE);
      count <= CW'(NFREE);
    end else begin
      if (push_ok) begin
        slot[tail] <= push_idx;
        tail       <= IW'(ring_inc(int'(tail), PHYS_REGS));
      end
      if (pop_ok)
        head <= IW'(ring_inc(int'(head), PHYS_REGS));
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end
endmodule

// File: rtl/rn_history.sv
module rn_history
  import pin_rename_pkg::*;
#(
  parameter int ARCH_REGS  = 8,
  parameter int PHYS_REGS  = 16,
  parameter int HIST_DEPTH = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          push,
  input  logic [$clog2(ARCH_REGS)-1:0]  push_arch,
  input  logic [$clog2(PHYS_REGS)-1:0]  push_new,
  input  logic [$clog2(PHYS_REGS)-1:0]  push_prev,
  input  logic                          pop_young,
  input  logic                          drop_old,
  output logic [$clog2(ARCH_REGS)-1:0]  y_arch,
  output logic [$clog2(PHYS_REGS)-1:0]  y_new,
  output logic [$clog2(PHYS_REGS)-1:0]  y_prev,
  output logic                          empty,
  output logic                          full,
  output logic [$clog2(HIST_DEPTH+1)-1:0] count
);
  localparam int AW = $clog2(ARCH_REGS);
  localparam int IW = $clog2(PHYS_REGS);
  localparam int HW = $clog2(HIST_DEPTH);
  localparam int CW = $clog2(HIST_DEPTH + 1);

  logic [AW-1:0] h_arch [HIST_DEPTH];
  logic [IW-1:0] h_new  [HIST_DEPTH];
  logic [IW-1:0] h_prev [HIST_DEPTH];
  logic [HW-1:0] head, tail, young;
  logic          do_push, do_drop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(HIST_DEPTH));
  assign young   = HW'(ring_dec(int'(tail), HIST_DEPTH));
  assign y_arch  = h_arch[young];
  assign y_new   = h_new[young];
  assign y_prev  = h_prev[young];
  assign do_push = push && !full;
  assign do_drop = drop_old && !empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else if (pop_young) begin
      if (!empty) begin
        tail  <= young;
        count <= count - 1'b1;
      end
    end else begin
      if (do_push) begin
        h_arch[tail] <= push_arch;
        h_new[tail]  <= push_new;
        h_prev[tail] <= push_prev;
        tail         <= HW'(ring_inc(int'(tail), HIST_DEPTH));
      end
      if (do_drop)
        head <= HW'(ring_inc(int'(head), HIST_DEPTH));
      count <= count + CW'(do_push) - CW'(do_drop);
    end
  end
endmodule

// File: rtl/rn_maptable.sv
module rn_maptable
  import pin_rename_pkg::*;
#(
  parameter int ARCH_REGS = 8,
  parameter int PHYS_REGS = 16,
  parameter int PIN_W     = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [$clog2(ARCH_REGS)-1:0] look_arch,
  output logic [$clog2(PHYS_REGS)-1:0] cur_phys,
  output logic [PIN_W-1:0]             cur_cnt,
  output logic [PIN_W:0]               cur_wtc,
  output logic                         cur_flag,
  input  logic                         alloc_en,
  input  logic [$clog2(ARCH_REGS)-1:0] alloc_arch,
  input  logic [$clog2(PHYS_REGS)-1:0] alloc_phys,
  input  logic [PIN_W-1:0]             alloc_pin,
  input  logic                         dec_en,
  input  logic [$clog2(PHYS_REGS)-1:0] dec_phys,
  input  logic                         rest_en,
  input  logic [$clog2(ARCH_REGS)-1:0] rest_arch,
  input  logic [$clog2(PHYS_REGS)-1:0] rest_phys
);
  localparam int IW = $clog2(PHYS_REGS);

  logic [IW-1:0]    amap  [ARCH_REGS];
  logic [PIN_W-1:0] pcnt  [PHYS_REGS];
  logic [PIN_W:0]   wtc   [PHYS_REGS];
  logic             pflag [PHYS_REGS];

  assign cur_phys = amap[look_arch];
  assign cur_cnt  = pcnt[cur_phys];
  assign cur_wtc  = wtc[cur_phys];
  assign cur_flag = pflag[cur_phys];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < ARCH_REGS; a++) amap[a] <= IW'(a);
      for (int p = 0; p < PHYS_REGS; p++) begin
        pcnt[p]  <= '0;
        wtc[p]   <= '0;
        pflag[p] <= 1'b0;
      end
    end else begin
      if (alloc_en) begin
        amap[alloc_arch]  <= alloc_phys;
        pcnt[alloc_phys]  <= alloc_pin;
        wtc[alloc_phys]   <= (PIN_W+1)'(fresh_wtc(int'(alloc_pin)));
        pflag[alloc_phys] <= (alloc_pin != '0);
      end
      if (dec_en)
        pcnt[dec_phys] <= PIN_W'(drain_one(int'(pcnt[dec_phys])));
      if (rest_en)
        amap[rest_arch] <= rest_phys;
    end
  end
endmodule

// File: rtl/pin_rename.sv
module pin_rename
  import pin_rename_pkg::*;
#(
  parameter int ARCH_REGS  = 8,
  parameter int PHYS_REGS  = 16,
  parameter int PIN_W      = 3,
  parameter int HIST_DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ren_valid,
  input  logic [$clog2(ARCH_REGS)-1:0] ren_arch,
  input  logic [PIN_W-1:0]             ren_pin,
  output logic                         ren_stall,
  output logic [$clog2(PHYS_REGS)-1:0] ren_phys,
  output logic [$clog2(PHYS_REGS)-1:0] ren_prev,
  output logic [PIN_W-1:0]             ren_left,
  output logic [PIN_W:0]               ren_wtc,
  output logic                         ren_pinned,
  output logic                         pin_error,
  output logic                         sb_clr_valid,
  output logic [$clog2(PHYS_REGS)-1:0] sb_clr_idx,
  input  logic                         free_valid,
  input  logic [$clog2(PHYS_REGS)-1:0] free_idx,
  input  logic                         squash_valid,
  input  logic                         retire_valid
);
  localparam int AW = $clog2(ARCH_REGS);
  localparam int IW = $clog2(PHYS_REGS);

  logic [IW-1:0]    cur_phys, fl_head, y_new, y_prev;
  logic [AW-1:0]    y_arch;
  logic [PIN_W-1:0] cur_cnt;
  logic [PIN_W:0]   cur_wtc;
  logic             cur_flag, fl_empty, hist_empty, hist_full;
  logic [$clog2(PHYS_REGS+1)-1:0]  fl_count;
  logic [$clog2(HIST_DEPTH+1)-1:0] hist_count;
  ren_kind_e        kind;
  logic             accept, fl_pop, dec_en, rest_en;

  // event decode
  always_comb begin
    if (ren_arch == '0)         kind = RK_ZERO;
    else if (cur_cnt != '0)     kind = RK_REUSE;
    else                        kind = RK_FRESH;
  end

  assign ren_stall = ren_valid &&
                     (squash_valid || hist_full || (kind == RK_FRESH && fl_empty));
  assign accept    = ren_valid && !ren_stall;
  assign fl_pop    = accept && (kind == RK_FRESH);
  assign dec_en    = accept && (kind == RK_REUSE);
  assign rest_en   = squash_valid && !hist_empty && (y_new != y_prev);

  assign ren_phys     = (kind == RK_FRESH) ? fl_head : cur_phys;
  assign ren_prev     = cur_phys;
  assign sb_clr_valid = accept;
  assign sb_clr_idx   = ren_phys;
  assign pin_error    = dec_en && (ren_pin != '0);

  always_comb begin
    case (kind)
      RK_FRESH: begin
        ren_left   = ren_pin;
        ren_wtc    = (PIN_W+1)'(fresh_wtc(int'(ren_pin)));
        ren_pinned = (ren_pin != '0);
      end
      RK_REUSE: begin
        ren_left   = PIN_W'(drain_one(int'(cur_cnt)));
        ren_wtc    = cur_wtc;
        ren_pinned = cur_flag;
      end
      default: begin
        ren_left   = cur_cnt;
        ren_wtc    = cur_wtc;
        ren_pinned = cur_flag;
      end
    endcase
  end

  rn_maptable #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS), .PIN_W(PIN_W)) u_map (
    .clk(clk), .rst_n(rst_n),
    .look_arch(ren_arch), .cur_phys(cur_phys), .cur_cnt(cur_cnt),
    .cur_wtc(cur_wtc), .cur_flag(cur_flag),
    .alloc_en(fl_pop), .alloc_arch(ren_arch), .alloc_phys(fl_head), .alloc_pin(ren_pin),
    .dec_en(dec_en), .dec_phys(cur_phys),
    .rest_en(rest_en), .rest_arch(y_arch), .rest_phys(y_prev)
  );

  rn_freelist #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_free (
    .clk(clk), .rst_n(rst_n),
    .pop(fl_pop), .push(free_valid), .push_idx(free_idx),
    .head_idx(fl_head), .empty(fl_empty), .count(fl_count)
  );

  rn_history #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS), .HIST_DEPTH(HIST_DEPTH)) u_hist (
    .clk(clk), .rst_n(rst_n),
    .push(accept), .push_arch(ren_arch), .push_new(ren_phys), .push_prev(cur_phys),
    .pop_young(squash_valid), .drop_old(retire_valid && !squash_valid),
    .y_arch(y_arch), .y_new(y_new), .y_prev(y_prev),
    .empty(hist_empty), .full(hist_full), .count(hist_count)
  );
endmodule

// File: rtl/rn_checker.sv
module rn_checker
  import pin_rename_pkg::*;
#(
  parameter int ARCH_REGS  = 8,
  parameter int PHYS_REGS  = 16,
  parameter int HIST_DEPTH = 16
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           ren_valid,
  input logic [$clog2(ARCH_REGS)-1:0]   ren_arch,
  input logic                           ren_stall,
  input logic [$clog2(PHYS_REGS)-1:0]   ren_phys,
  input logic [$clog2(PHYS_REGS)-1:0]   ren_prev,
  input logic                           ren_pinned,
  input logic                           pin_error,
  input logic                           sb_clr_valid,
  input logic                           squash_valid,
  input ren_kind_e                      kind,
  input logic                           fl_pop,
  input logic [$clog2(PHYS_REGS+1)-1:0] fl_count,
  input logic [$clog2(HIST_DEPTH+1)-1:0] hist_count
);
  // R2
  zero_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_clr_valid && ren_arch == '0) |-> (ren_phys == '0 && ren_prev == '0 && !fl_pop));

  // R5
  reuse_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_clr_valid && kind == RK_REUSE) |-> (ren_phys == ren_prev && !fl_pop));

  // R6
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_clr_valid && kind == RK_REUSE) |-> ren_pinned);

  // R7
  pin_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_error |-> (sb_clr_valid && ren_phys == ren_prev));

  // R9
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_pop |-> (fl_count != '0));

  // R12
  squash_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (squash_valid && ren_valid) |-> (ren_stall && !sb_clr_valid));

  // R11
  squash_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (squash_valid && hist_count != '0) |=> (hist_count == $past(hist_count) - 1'b1));
endmodule

bind pin_rename rn_checker #(
  .ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS), .HIST_DEPTH(HIST_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_arch(ren_arch),
  .ren_stall(ren_stall), .ren_phys(ren_phys), .ren_prev(ren_prev),
  .ren_pinned(ren_pinned), .pin_error(pin_error), .sb_clr_valid(sb_clr_valid),
  .squash_valid(squash_valid), .kind(kind), .fl_pop(fl_pop),
  .fl_count(fl_count), .hist_count(hist_count)
);

// File: tb/pin_rename_tb.sv
module pin_rename_tb;
  localparam int ARCH = 8;
  localparam int PHYS = 16;
  localparam int PW   = 3;
  localparam int HD   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ren_valid = 1'b0, free_valid = 1'b0, squash_valid = 1'b0, retire_valid = 1'b0;
  logic [2:0] ren_arch = '0;
  logic [PW-1:0] ren_pin = '0;
  logic [3:0] free_idx = '0;
  logic ren_stall, ren_pinned, pin_error, sb_clr_valid;
  logic [3:0] ren_phys, ren_prev, sb_clr_idx;
  logic [PW-1:0] ren_left;
  logic [PW:0] ren_wtc;

  pin_rename #(.ARCH_REGS(ARCH), .PHYS_REGS(PHYS), .PIN_W(PW), .HIST_DEPTH(HD)) u_dut (
    .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_arch(ren_arch), .ren_pin(ren_pin),
    .ren_stall(ren_stall), .ren_phys(ren_phys), .ren_prev(ren_prev), .ren_left(ren_left),
    .ren_wtc(ren_wtc), .ren_pinned(ren_pinned), .pin_error(pin_error),
    .sb_clr_valid(sb_clr_valid), .sb_clr_idx(sb_clr_idx), .free_valid(free_valid),
    .free_idx(free_idx), .squash_valid(squash_valid), .retire_valid(retire_valid)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;

  typedef struct {
    int phys; int prev; int left; int wtc; int pinned; int perr; string tag;
  } exp_t;
  typedef struct { int arch; int nw; int pv; } hist_t;

  exp_t  expq[$];
  hist_t hq[$];
  int    fq[$];
  int    mmap [ARCH];
  int    pcnt [PHYS];
  int    mwtc [PHYS];
  int    mflg [PHYS];

  task automatic check(bit ok, string tag, string act, string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %s expected %s", tag, act, exp);
    end
  endtask

  // monitor: compares accepted renames against the queued expectations
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && ren_valid && !ren_stall) begin
        if (expq.size() == 0) begin
          check(1'b0, "R8", "unexpected accept", "stall");
        end else begin
          exp_t e;
          e = expq.pop_front();
          check(int'(ren_phys) == e.phys && int'(ren_prev) == e.prev &&
                int'(sb_clr_idx) == e.phys && sb_clr_valid,
                {e.tag, " R8 map"},
                $sformatf("phys=%0d prev=%0d sb=%0d/%0b", ren_phys, ren_prev, sb_clr_idx, sb_clr_valid),
                $sformatf("phys=%0d prev=%0d sb=%0d/1", e.phys, e.prev, e.phys));
          check(int'(ren_left) == e.left && int'(ren_wtc) == e.wtc &&
                int'(ren_pinned) == e.pinned && int'(pin_error) == e.perr,
                {e.tag, " cnt"},
                $sformatf("left=%0d wtc=%0d pin=%0b err=%0b", ren_left, ren_wtc, ren_pinned, pin_error),
                $sformatf("left=%0d wtc=%0d pin=%0d err=%0d", e.left, e.wtc, e.pinned, e.perr));
        end
      end
    end
  end

  // driver: predicts the outcome from the requirements
  task automatic do_ren(int a, int p, string tag);
    int cur;
    bit fresh, stall;
    cur   = mmap[a];
    fresh = (a != 0) && (pcnt[cur] == 0);
    stall = (hq.size() == HD) || (fresh && fq.size() == 0);
    ren_valid = 1'b1; ren_arch = 3'(a); ren_pin = PW'(p);
    if (stall) begin
      @(negedge clk); #1;
      check(ren_stall && !sb_clr_valid, {tag, " stall"},
            $sformatf("stall=%0b clr=%0b", ren_stall, sb_clr_valid), "stall=1 clr=0");
    end else begin
      exp_t e;
      e.tag = tag; e.prev = cur; e.perr = 0;
      if (a == 0) begin
        e.phys = 0; e.left = pcnt[0]; e.wtc = mwtc[0]; e.pinned = mflg[0];
      end else if (!fresh) begin
        e.perr = (p != 0);
        e.phys = cur; pcnt[cur]--; e.left = pcnt[cur];
        e.wtc = mwtc[cur]; e.pinned = mflg[cur];
      end else begin
        e.phys = fq.pop_front(); mmap[a] = e.phys;
        pcnt[e.phys] = p; mwtc[e.phys] = p + 1; mflg[e.phys] = (p != 0);
        e.left = p; e.wtc = p + 1; e.pinned = (p != 0);
      end
      hq.push_back('{arch: a, nw: e.phys, pv: cur});
      expq.push_back(e);
      @(negedge clk);
    end
    @(posedge clk); #1;
    ren_valid = 1'b0;
  endtask

  task automatic do_squash(bit with_ren);
    squash_valid = 1'b1;
    ren_valid = with_ren; ren_arch = 3'd1; ren_pin = '0;
    if (hq.size() != 0) begin
      hist_t h;
      h = hq.pop_back();
      if (h.nw != h.pv) mmap[h.arch] = h.pv;
    end
    @(negedge clk); #1;
    if (with_ren)
      // R12: squash blocks rename
      check(ren_stall && !sb_clr_valid, "R12 squash",
            $sformatf("stall=%0b clr=%0b", ren_stall, sb_clr_valid), "stall=1 clr=0");
    @(posedge clk); #1;
    squash_valid = 1'b0; ren_valid = 1'b0;
  endtask

  task automatic do_retire();
    retire_valid = 1'b1;
    if (hq.size() != 0) void'(hq.pop_front());
    @(posedge clk); #1;
    retire_valid = 1'b0;
  endtask

  task automatic do_free(int idx);
    free_valid = 1'b1; free_idx = 4'(idx);
    fq.push_back(idx);
    @(posedge clk); #1;
    free_valid = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < ARCH; i++) mmap[i] = i;
    for (int i = 0; i < PHYS; i++) begin pcnt[i] = 0; mwtc[i] = 0; mflg[i] = 0; end
    for (int i = ARCH; i < PHYS; i++) fq.push_back(i);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    check(!sb_clr_valid && !ren_stall && !pin_error, "R1 reset",
          $sformatf("clr=%0b stall=%0b err=%0b", sb_clr_valid, ren_stall, pin_error), "all 0");
    @(posedge clk); #1;

    do_ren(0, 0, "R2 zero");
    do_ren(1, 0, "R1 R3 first alloc");
    do_ren(2, 3, "R3 R4 pinned alloc");
    do_ren(2, 0, "R5 reuse a");
    do_ren(2, 0, "R5 reuse b");
    do_ren(2, 0, "R6 drain to zero");
    do_ren(2, 0, "R3 after drain");
    do_ren(3, 2, "R4 pin two");
    do_ren(3, 1, "R7 pin on pinned");
    do_squash(1'b1);
    do_squash(1'b0);
    do_squash(1'b0);
    do_ren(2, 0, "R11 restored arch2");
    do_ren(3, 0, "R11 restored arch3");
    do_ren(4, 0, "R3 take 14");
    do_ren(4, 0, "R3 take 15");
    do_ren(4, 0, "R9 pool empty");
    do_ren(0, 0, "R9 R2 zero while empty");
    do_free(10);
    do_free(9);
    do_ren(5, 0, "R10 first returned");
    do_ren(6, 0, "R10 second returned");
    while (hq.size() != 0) do_retire();
    for (int i = 0; i < HD; i++) do_ren(0, 0, "R2 fill history");
    do_ren(0, 0, "R12 history full");
    while (hq.size() != 0) do_retire();
    do_free(11);
    do_ren(7, 1, "R4 pin one");
    do_retire();
    do_squash(1'b0);
    do_ren(7, 0, "R13 retired survives squash");

    repeat (3) @(posedge clk);
    check(expq.size() == 0, "R8 drain", $sformatf("%0d pending", expq.size()), "0 pending");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule